// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight-bit condition and control byte of a small processor core. Bit 7 is the global interrupt enable, bit 6 is a one-bit transfer cell used to move single bits in and out of register-file bytes, and bits 5 down to 0 hold the arithmetic condition flags: half carry, sign, overflow, negative, zero and carry. The whole byte is always visible on one output, so branch logic and interrupt logic can read it directly.

Several sources can change the byte. The ALU supplies new half-carry, overflow, negative, zero and carry values, along with a five-bit mask that selects which of them take effect. Whenever the overflow or negative flag is written, the sign flag is rebuilt as their exclusive OR. The data bus can overwrite the whole byte in one cycle, which lets software save the flags and restore them later. Four single-cycle control pulses manage the interrupt enable: interrupt accepted, return from interrupt, enable and disable. A bit-store operation copies one selected bit of a register-file byte into the transfer cell. A bit-load output returns that byte with the selected bit replaced by the transfer cell.

All updates happen on the rising clock edge. Reset is synchronous and active-high. The block does not save the byte automatically on interrupt entry or return.

Top module: `cpu_status_reg`

## Requirements
- R1: A clock edge with `rst` high clears all eight bits of `status` to 0. The bit order is [7]=interrupt enable, [6]=transfer bit, [5]=half carry, [4]=sign, [3]=overflow, [2]=negative, [1]=zero, [0]=carry.
- R2: When `wr_en` is high, the next `status` equals `wr_data` exactly. This holds even when the sign bit disagrees with negative XOR overflow, and it holds whatever other inputs are active in that cycle.
- R3: When `irq_take` is high and `wr_en` is low, the interrupt enable bit is 0 after the edge, even if `irq_ret`, `ie_set` or `ie_clr` is also high.
- R4: When `wr_en` and `irq_take` are low, `irq_ret` or `ie_set` sets the interrupt enable bit. `ie_clr` alone clears it. If set and clear are both high, set wins. With none of these pulses active, the bit holds its value.
- R5: When `alu_en` is high, each flag whose `alu_mask` bit is 1 takes its new value from `alu_flags`, and the other flags keep their values. The mask and flag bit mapping is [4]=half carry, [3]=overflow, [2]=negative, [1]=zero, [0]=carry. When `alu_en` is low, no arithmetic flag changes.
- R6: When an ALU update selects overflow or negative, the sign bit becomes the XOR of the negative and overflow values that hold after the update. Otherwise the sign bit keeps its value, unless a bus write occurs.
- R7: When `bst_en` is high and `wr_en` is low, the transfer bit becomes `rf_byte[bit_sel]`. Otherwise it holds its value, unless a bus write occurs.
- R8: `bld_byte` always equals `rf_byte` with bit `bit_sel` replaced by the current transfer bit (`status[6]`). It responds combinationally.
- R9: When several events occur in one cycle without a bus write, the interrupt events, the ALU update and the bit store each change only their own bits, and all of those changes take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Full-byte write from the data bus |
| wr_data | input | 8 | Byte to be written |
| irq_take | input | 1 | Interrupt accepted pulse |
| irq_ret | input | 1 | Return-from-interrupt pulse |
| ie_set | input | 1 | Enable-interrupts pulse |
| ie_clr | input | 1 | Disable-interrupts pulse |
| alu_en | input | 1 | ALU flag update strobe |
| alu_mask | input | 5 | Per-flag update select (H,V,N,Z,C) |
| alu_flags | input | 5 | New flag values (H,V,N,Z,C) |
| bst_en | input | 1 | Bit-store strobe |
| rf_byte | input | 8 | Register-file byte for bit store or bit load |
| bit_sel | input | 3 | Bit index into rf_byte |
| bld_byte | output | 8 | rf_byte with the indexed bit replaced by the transfer bit |
| status | output | 8 | Current register value |

## Verification
The in-line assertions check on every cycle the properties that hold whatever the inputs are. These are the cleared state after reset, the exact copy of a bus write, the interrupt enable dropping when an interrupt is accepted or rising on return or enable, sign consistency after an ALU update that touches negative or overflow, and arithmetic flags and the transfer bit holding their values when nothing addresses them. Other behaviours need a reference model, and only the bench scenarios can show them. These include the per-flag mask mapping, the order in which set and clear resolve against each other, bit selection by index for store and load, and several events combining in one cycle. The bench covers them with seeded random traffic and directed corner cases.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int SR_W    = 8;
  localparam int SEL_W   = $clog2(SR_W);
  localparam int AF_W    = 5;
  localparam int POS_IE  = 7;
  localparam int POS_TB  = 6;
  localparam int POS_HC  = 5;
  localparam int POS_SG  = 4;
  localparam int POS_OV  = 3;
  localparam int POS_NG  = 2;
  localparam int POS_ZR  = 1;
  localparam int POS_CY  = 0;
  localparam int ARITH_W = POS_HC + 1;

  // position in the status byte of ALU mask bit k (k: 4=H,3=V,2=N,1=Z,0=C)
  function automatic int mask_to_pos(input int k);
    case (k)
      4:       return POS_HC;
      3:       return POS_OV;
      2:       return POS_NG;
      1:       return POS_ZR;
      default: return POS_CY;
    endcase
  endfunction
endpackage

// File: rtl/sreg_ie_ctrl.sv
module sreg_ie_ctrl (
  input  logic cur_ie,
  input  logic wr_en,
  input  logic wr_ie,
  input  logic take,
  input  logic ret,
  input  logic set,
  input  logic clr,
  output logic nxt_ie
);
  always_comb begin
    if (wr_en)            nxt_ie = wr_ie;
    else if (take)        nxt_ie = 1'b0;
    else if (ret || set)  nxt_ie = 1'b1;
    else if (clr)         nxt_ie = 1'b0;
    else                  nxt_ie = cur_ie;
  end
endmodule

// File: rtl/sreg_flag_merge.sv
module sreg_flag_merge
  import sreg_pkg::*;
(
  input  logic [ARITH_W-1:0] cur,
  input  logic               upd,
  input  logic [AF_W-1:0]    mask,
  input  logic [AF_W-1:0]    vals,
  output logic [ARITH_W-1:0] nxt
);
  logic [ARITH_W-1:0] merged;

  always_comb merged[POS_SG] = cur[POS_SG];

  for (genvar k = 0; k < AF_W; k++) begin : g_flag
    localparam int P = mask_to_pos(k);
    assign merged[P] = (upd && mask[k]) ? vals[k] : cur[P];
  end

  logic touch_sign;
  assign touch_sign = upd && (mask[3] || mask[2]);

  always_comb begin
    nxt = merged;
    if (touch_sign) nxt[POS_SG] = merged[POS_NG] ^ merged[POS_OV];
  end
endmodule

// File: rtl/sreg_bit_copy.sv
module sreg_bit_copy #(
  parameter int W  = 8,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  src,
  input  logic [SW-1:0] sel,
  input  logic          tbit,
  output logic          picked,
  output logic [W-1:0]  loaded
);
  assign picked = src[sel];
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign loaded[b] = (sel == SW'(b)) ? tbit : src[b];
  end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SR_W-1:0]   wr_data,
  input  logic              irq_take,
  input  logic              irq_ret,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              alu_en,
  input  logic [AF_W-1:0]   alu_mask,
  input  logic [AF_W-1:0]   alu_flags,
  input  logic              bst_en,
  input  logic [SR_W-1:0]   rf_byte,
  input  logic [SEL_W-1:0]  bit_sel,
  output logic [SR_W-1:0]   bld_byte,
  output logic [SR_W-1:0]   status
);
  logic [SR_W-1:0]    sr_q, sr_d;
  logic               ie_d, picked;
  logic [ARITH_W-1:0] arith_d;

  sreg_ie_ctrl u_ie (
    .cur_ie(sr_q[POS_IE]), .wr_en(wr_en), .wr_ie(wr_data[POS_IE]),
    .take(irq_take), .ret(irq_ret), .set(ie_set), .clr(ie_clr),
    .nxt_ie(ie_d)
  );

  sreg_flag_merge u_flags (
    .cur(sr_q[ARITH_W-1:0]), .upd(alu_en), .mask(alu_mask),
    .vals(alu_flags), .nxt(arith_d)
  );

  sreg_bit_copy #(.W(SR_W), .SW(SEL_W)) u_copy (
    .src(rf_byte), .sel(bit_sel), .tbit(sr_q[POS_TB]),
    .picked(picked), .loaded(bld_byte)
  );

  always_comb begin
    if (wr_en) begin
      sr_d = wr_data;
    end else begin
      sr_d[POS_IE]        = ie_d;
      sr_d[POS_TB]        = bst_en ? picked : sr_q[POS_TB];
      sr_d[ARITH_W-1:0]   = arith_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= sr_d;
  end

  assign status = sr_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> status == '0);
  // R2
  bus_copy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> status == $past(wr_data));
  // R3
  take_drops_ie_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_take && !wr_en) |=> !status[POS_IE]);
  // R4
  ret_raises_ie_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq_ret || ie_set) && !irq_take && !wr_en) |=> status[POS_IE]);
  // R6
  sign_consistent_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_en && (alu_mask[3] || alu_mask[2]) && !wr_en)
      |=> status[POS_SG] == (status[POS_NG] ^ status[POS_OV]));
  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!alu_en && !wr_en) |=> $stable(status[ARITH_W-1:0]));
  // R7
  tbit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bst_en && !wr_en) |=> $stable(status[POS_TB]));
endmodule

// File: tb/cpu_status_reg_bench.sv
`timescale 1ns/1ps
module cpu_status_reg_bench;
  logic       clk = 0, rst = 1;
  logic       wr_en = 0, irq_take = 0, irq_ret = 0, ie_set = 0, ie_clr = 0;
  logic       alu_en = 0, bst_en = 0;
  logic [7:0] wr_data = 0, rf_byte = 0;
  logic [4:0] alu_mask = 0, alu_flags = 0;
  logic [2:0] bit_sel = 0;
  logic [7:0] bld_byte, status;
  logic [7:0] model = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cpu_status_reg u_cpu_status_reg (.*);

  function automatic logic [7:0] next_model(input logic [7:0] s);
    logic [7:0] n;
    int pos [5] = '{0, 1, 2, 3, 5};
    n = s;
    if (wr_en) return wr_data;
    if (irq_take) n[7] = 0;
    else if (irq_ret || ie_set) n[7] = 1;
    else if (ie_clr) n[7] = 0;
    if (bst_en) n[6] = rf_byte[bit_sel];
    if (alu_en) begin
      for (int k = 0; k < 5; k++) if (alu_mask[k]) n[pos[k]] = alu_flags[k];
      if (alu_mask[3] || alu_mask[2]) n[4] = n[2] ^ n[3];
    end
    return n;
  endfunction

  function automatic logic [7:0] exp_load(input logic [7:0] b, input logic [2:0] i, input logic t);
    logic [7:0] r = b;
    r[i] = t;
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; irq_take = 0; irq_ret = 0; ie_set = 0; ie_clr = 0;
    alu_en = 0; bst_en = 0;
  endtask

  // inputs set at negedge; apply one edge, update model, check at next negedge
  task automatic step(input string req);
    #1 check("R8 bld_byte", bld_byte, exp_load(rf_byte, bit_sel, model[6]));
    @(posedge clk);
    model = next_model(model);
    @(negedge clk);
    check(req, status, model);
    idle();
  endtask

  function automatic string tag_of();
    if (wr_en) return "R2";
    if (irq_take) return "R3";
    if (irq_ret || ie_set || ie_clr) return "R4";
    if (alu_en && (alu_mask[3] || alu_mask[2])) return "R6";
    if (alu_en) return "R5";
    if (bst_en) return "R7";
    return "R9";
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (2) @(negedge clk);
    rst = 0;
    model = 0;
    check("R1 reset", status, 8'h00);
    // R2: full write, inconsistent sign kept
    wr_en = 1; wr_data = 8'h10; alu_en = 1; alu_mask = 5'h1F; alu_flags = 5'h1F;
    irq_take = 1; step("R2");
    wr_en = 1; wr_data = 8'hFF; step("R2");
    // R3: take beats return/set
    irq_take = 1; irq_ret = 1; ie_set = 1; step("R3");
    // R4: set beats clear, clear alone
    ie_set = 1; ie_clr = 1; step("R4");
    ie_clr = 1; step("R4");
    irq_ret = 1; step("R4");
    // R6: only V updated with N=1,V=0 -> S=1
    wr_en = 1; wr_data = 8'h04; step("R2");
    alu_en = 1; alu_mask = 5'b01000; alu_flags = 5'b00000; step("R6");
    // R5: mask Z only; other flags kept
    alu_en = 1; alu_mask = 5'b00010; alu_flags = 5'b11111; step("R5");
    // R7: bit store from each index
    for (int i = 0; i < 8; i++) begin
      bst_en = 1; rf_byte = 8'h01 << i; bit_sel = 3'(i); step("R7");
      bst_en = 1; rf_byte = ~(8'h01 << i); bit_sel = 3'(i); step("R7");
    end
    // R9: combined events
    irq_take = 1; alu_en = 1; alu_mask = 5'h1F; alu_flags = 5'b10101;
    bst_en = 1; rf_byte = 8'h80; bit_sel = 7; step("R9");
    // random
    for (int n = 0; n < 3000; n++) begin
      wr_en    = ($urandom % 10) == 0;
      wr_data  = 8'($urandom);
      irq_take = ($urandom % 6) == 0;
      irq_ret  = ($urandom % 6) == 0;
      ie_set   = ($urandom % 6) == 0;
      ie_clr   = ($urandom % 4) == 0;
      alu_en   = ($urandom % 2) == 0;
      alu_mask = 5'($urandom);
      alu_flags= 5'($urandom);
      bst_en   = ($urandom % 3) == 0;
      rf_byte  = 8'($urandom);
      bit_sel  = 3'($urandom);
      step(tag_of());
    end
    // R1: reset mid-run
    wr_en = 1; wr_data = 8'hFF; step("R2");
    rst = 1; @(posedge clk); @(negedge clk); rst = 0; model = 0;
    check("R1 reset", status, 8'h00);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule